// File: doc/BRIEF.md
# Nibble Check-Code Fuse Image Writer

This block takes a run of data bytes and lays them into a byte-wide one-time-programmable array, starting at an offset the caller chooses. Every 4-bit nibble is widened into one 8-bit code word. The nibble itself sits in the low half. The upper half carries four check bits, each the XOR of a pair of nibble bits. One input byte therefore costs two array bytes: the code for its low nibble goes first, and the code for its high nibble goes into the next address.

A transfer opens with a command that carries a start offset and a byte count. If the encoded image would run past the end of the array, the command is refused with a one-cycle error pulse and nothing is written. Otherwise the data bytes arrive on a valid/ready stream at no more than one byte every two clocks. The block drives one array write per clock until the image is complete, then gives a one-cycle done pulse.

Top module: `nibble_code_writer`

## Requirements
- R1: On every array write, wr_data[3:0] equals the source nibble unchanged.
- R2: On every array write, wr_data[4] = d0 XOR d1 and wr_data[5] = d2 XOR d3, where d is the source nibble.
- R3: On every array write, wr_data[6] = d0 XOR d2 and wr_data[7] = d1 XOR d3.
- R4: A byte accepted on the stream is written as the code of in_data[3:0] in the cycle after acceptance, at the current address. The code of in_data[7:4] follows in the next cycle, at that address plus one.
- R5: A command with offset O and count L>0 produces exactly 2*L writes, to addresses O through O+2L-1 in rising order.
- R6: A command with O+2L greater than DEPTH (1024 bytes by default) makes err high for exactly one cycle, in the cycle after the command is taken. No write follows, and the block stays ready for a new command. O+2L equal to DEPTH is accepted.
- R7: in_ready is low in the cycle after each accepted byte, so the stream carries at most one byte per two clocks.
- R8: done is high for exactly one cycle, in the cycle right after the final write of a transfer.
- R9: After reset, cmd_ready is 1 and in_ready, wr_en, done and err are 0.
- R10: A command with count 0 makes no write and raises done in the cycle after it is taken.
- R11: cmd_ready is high only while no transfer is in progress. A command held on the inputs during a transfer has no effect on the write addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken on valid |
| cmd_offset | input | AW | First array byte address |
| cmd_len | input | AW | Number of input bytes |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Data byte taken on valid |
| in_data | input | 8 | Data byte |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | AW | Array byte address |
| wr_data | output | 8 | Encoded code byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle out-of-bounds rejection pulse |

AW is $clog2(DEPTH), which is 10 for the default DEPTH of 1024.

## Verification
The bench builds the block with the default depth of 1024 bytes and a 10-bit address. This keeps the array end within a few hundred cycles of stimulus. The full 512-byte image from offset 0 ends exactly on the last address. The bound is probed on both sides of the limit: a single byte at offset 1022 is accepted, while one at 1023 and a 513-byte run from zero are refused. Random offsets and counts, with random stream gaps, bring all sixteen nibble codes and both pacing regimes (back-to-back and stalled) into reach.

// File: rtl/nce_pkg.sv
package nce_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 8;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int NIBS   = BYTE_W / NIB_W;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOW  = 2'd1,
    SQ_HIGH = 2'd2,
    SQ_FIN  = 2'd3
  } sq_state_e;

  // Widen one nibble into a code word: data in [3:0], pair parities above.
  function automatic logic [CODE_W-1:0] nce_encode(input logic [NIB_W-1:0] n);
    logic [NIB_W-1:0] chk;
    chk[0] = n[0] ^ n[1];
    chk[1] = n[2] ^ n[3];
    chk[2] = n[0] ^ n[2];
    chk[3] = n[1] ^ n[3];
    return {chk, n};
  endfunction

  // Encoded image end (exclusive) for a start offset and a byte count.
  function automatic logic [31:0] nce_span_end(input logic [31:0] off, input logic [31:0] len);
    return off + (len << 1);
  endfunction
endpackage

// File: rtl/nce_encoder.sv
module nce_encoder
  import nce_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CODE_W-1:0] code_lo,
  output logic [CODE_W-1:0] code_hi
);
  logic [NIBS-1:0][CODE_W-1:0] codes;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign codes[g] = nce_encode(byte_in[g*NIB_W +: NIB_W]);
  end

  assign code_lo = codes[0];
  assign code_hi = codes[NIBS-1];
endmodule

// File: rtl/nce_bounds.sv
module nce_bounds
  import nce_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0] off,
  input  logic [AW-1:0] len,
  output logic          over,
  output logic          zero
);
  logic [31:0] span_end;

  always_comb begin
    span_end = nce_span_end(32'(off), 32'(len));
    over     = span_end > 32'(DEPTH);
    zero     = (len == '0);
  end
endmodule

// File: rtl/nce_sequencer.sv
module nce_sequencer
  import nce_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic              cmd_over,
  input  logic              cmd_zero,
  input  logic [AW-1:0]     cmd_off,
  input  logic [AW-1:0]     cmd_len,
  input  logic              byte_fire,
  input  logic [CODE_W-1:0] code_lo,
  input  logic [CODE_W-1:0] code_hi,
  output logic              idle,
  output logic              take_byte,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [CODE_W-1:0] wr_data,
  output logic              done,
  output logic              err
);
  sq_state_e         state;
  logic [AW-1:0]     addr;
  logic [AW-1:0]     remain;
  logic [CODE_W-1:0] hi_q;
  logic              last_byte;

  assign idle      = (state == SQ_IDLE);
  assign take_byte = (state == SQ_LOW);
  assign last_byte = (remain == AW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      addr    <= '0;
      remain  <= '0;
      hi_q    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (cmd_fire) begin
            if (cmd_over) begin
              err <= 1'b1;
            end else if (cmd_zero) begin
              done <= 1'b1;
            end else begin
              addr   <= cmd_off;
              remain <= cmd_len;
              state  <= SQ_LOW;
            end
          end
        end
        SQ_LOW: begin
          if (byte_fire) begin
            wr_en   <= 1'b1;
            wr_addr <= addr;
            wr_data <= code_lo;
            hi_q    <= code_hi;
            state   <= SQ_HIGH;
          end
        end
        SQ_HIGH: begin
          wr_en   <= 1'b1;
          wr_addr <= addr + AW'(1);
          wr_data <= hi_q;
          addr    <= addr + AW'(2);
          remain  <= remain - AW'(1);
          state   <= last_byte ? SQ_FIN : SQ_LOW;
        end
        SQ_FIN: begin
          done  <= 1'b1;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nibble_code_writer.sv
module nibble_code_writer
  import nce_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_offset,
  input  logic [AW-1:0] cmd_len,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          err
);
  logic              cmd_fire;
  logic              byte_fire;
  logic              cmd_over;
  logic              cmd_zero;
  logic [CODE_W-1:0] code_lo;
  logic [CODE_W-1:0] code_hi;

  assign cmd_fire  = cmd_valid && cmd_ready;
  assign byte_fire = in_valid && in_ready;

  nce_bounds #(.DEPTH(DEPTH)) u_bounds (
    .off  (cmd_offset),
    .len  (cmd_len),
    .over (cmd_over),
    .zero (cmd_zero)
  );

  nce_encoder u_enc (
    .byte_in (in_data),
    .code_lo (code_lo),
    .code_hi (code_hi)
  );

  nce_sequencer #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_fire),
    .cmd_over  (cmd_over),
    .cmd_zero  (cmd_zero),
    .cmd_off   (cmd_offset),
    .cmd_len   (cmd_len),
    .byte_fire (byte_fire),
    .code_lo   (code_lo),
    .code_hi   (code_hi),
    .idle      (cmd_ready),
    .take_byte (in_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (done),
    .err       (err)
  );
endmodule

// File: rtl/nce_checker.sv
module nce_checker #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          byte_fire,
  input logic          in_ready,
  input logic [7:0]    in_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          done,
  input logic          err
);
  AST_KEEP_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(byte_fire) |-> wr_en && wr_data[3:0] == $past(in_data[3:0])); // R1

  AST_HIGH_NIBBLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(byte_fire, 2) |-> wr_en && wr_data[3:0] == $past(in_data[7:4], 2)); // R4

  AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data[4] == (wr_data[0] ^ wr_data[1]) && wr_data[5] == (wr_data[2] ^ wr_data[3])); // R2

  AST_PAIR_STRIDED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_data[6] == (wr_data[0] ^ wr_data[2]) && wr_data[7] == (wr_data[1] ^ wr_data[3])); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == AW'($past(wr_addr) + AW'(1))); // R5

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !wr_en && cmd_ready); // R6

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err && !wr_en); // R6

  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(byte_fire) |-> !in_ready); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en); // R8

  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cmd_ready); // R11

  AST_ONE_SIDE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && in_ready)); // R11
endmodule

bind nibble_code_writer nce_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .byte_fire (byte_fire),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .done      (done),
  .err       (err)
);

// File: tb/nibble_code_writer_bench.sv
module nibble_code_writer_bench;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_offset = '0;
  logic [AW-1:0] cmd_len = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          done;
  logic          err;

  nibble_code_writer #(.DEPTH(DEPTH)) u_nibble_code_writer (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [AW-1:0] exp_a [DEPTH];
  logic [7:0]    exp_d [DEPTH];
  logic [7:0]    src   [DEPTH/2];
  int n_exp = 0;
  int wi = 0;

  function automatic logic [7:0] ref_code(input logic [3:0] n);
    logic [7:0] c;
    c = {4'h0, n};
    c[4] = ^(n & 4'b0011);
    c[5] = ^(n & 4'b1100);
    c[6] = ^(n & 4'b0101);
    c[7] = ^(n & 4'b1010);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // write monitor: every array write is compared to the expected image
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (wi < n_exp) begin
        chk(wr_addr == exp_a[wi], "R5 write address", int'(wr_addr), int'(exp_a[wi]));
        chk(wr_data == exp_d[wi], "R1/R2/R3/R4 code byte", int'(wr_data), int'(exp_d[wi]));
      end else begin
        chk(1'b0, "R5 unexpected write", int'(wr_addr), -1);
      end
      wi++;
    end
  end

  task automatic send_cmd(input int off, input int len);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_offset = AW'(off);
    cmd_len    = AW'(len);
    chk(cmd_ready, "R11 idle accepts command", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic xfer(input int off, input int len, input bit gaps, input bit busy_cmd);
    n_exp = 2 * len;
    wi = 0;
    for (int i = 0; i < len; i++) begin
      exp_a[2*i]   = AW'(off + 2*i);
      exp_d[2*i]   = ref_code(src[i][3:0]);
      exp_a[2*i+1] = AW'(off + 2*i + 1);
      exp_d[2*i+1] = ref_code(src[i][7:4]);
    end
    send_cmd(off, len);
    chk(err == 1'b0, "R6 in-bounds command not refused", int'(err), 0);
    if (len == 0) begin
      chk(done == 1'b1, "R10 zero count done", int'(done), 1);
      @(negedge clk);
      chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
      chk(wi == 0, "R10 zero count writes", wi, 0);
      return;
    end
    for (int i = 0; i < len; i++) begin
      if (gaps) repeat ($urandom % 3) @(negedge clk);
      if (busy_cmd) begin
        cmd_valid  = 1'b1;
        cmd_offset = AW'(off + 7);
        cmd_len    = AW'(1);
      end
      in_valid = 1'b1;
      in_data  = src[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (busy_cmd) begin
        chk(cmd_ready == 1'b0, "R11 busy refuses command", int'(cmd_ready), 0);
        if (i == len - 1) cmd_valid = 1'b0;
      end
      chk(in_ready == 1'b0, "R7 ready low after byte", int'(in_ready), 0);
      chk(wr_en && wr_data == ref_code(src[i][3:0]), "R4 low nibble first",
          int'(wr_data), int'(ref_code(src[i][3:0])));
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done not with last write", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R8 done after last write", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", int'(done), 0);
    chk(wi == 2 * len, "R5 write count", wi, 2 * len);
  endtask

  task automatic bad_cmd(input int off, input int len);
    n_exp = 0;
    wi = 0;
    send_cmd(off, len);
    chk(err == 1'b1, "R6 out-of-bounds refused", int'(err), 1);
    chk(done == 1'b0, "R6 no done on refusal", int'(done), 0);
    @(negedge clk);
    chk(err == 1'b0, "R6 err single cycle", int'(err), 0);
    repeat (3) @(negedge clk);
    chk(wi == 0, "R6 no writes after refusal", wi, 0);
    chk(cmd_ready == 1'b1 && in_ready == 1'b0, "R6 stays idle", int'({cmd_ready, in_ready}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 reset cmd_ready", int'(cmd_ready), 1);
    chk({in_ready, wr_en, done, err} == 4'b0, "R9 reset outputs",
        int'({in_ready, wr_en, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    src[0] = 8'hA5;
    xfer(0, 1, 1'b0, 1'b0);
    src[0] = 8'h3C; src[1] = 8'hF0;
    xfer(1020, 2, 1'b0, 1'b0);          // ends exactly at the array end
    src[0] = 8'h96;
    xfer(1022, 1, 1'b0, 1'b0);
    bad_cmd(1023, 1);                   // one byte past the end
    bad_cmd(0, 513);
    bad_cmd(1000, 100);
    xfer(10, 0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) src[i] = 8'(8'h11 * (i + 3));
    xfer(100, 4, 1'b0, 1'b1);
    for (int i = 0; i < 512; i++) src[i] = 8'(i * 37 + 5);
    xfer(0, 512, 1'b0, 1'b0);
    for (int t = 0; t < 25; t++) begin
      int len;
      int off;
      len = 1 + ($urandom % 24);
      off = $urandom % (DEPTH - 2 * len + 1);
      for (int i = 0; i < len; i++) src[i] = 8'($urandom);
      xfer(off, len, t[0], 1'b0);
    end
    finish_run();
  end
endmodule